// File: doc/BRIEF.md
# Audio Sample FIFO Service Controller

This block sits beside a transmit sample FIFO and a receive sample FIFO and turns their fill levels into everything software and a DMA engine need to keep audio flowing. It derives four level flags, two threshold-driven service flags picked by 2-bit codes, request and panic lines for both directions, and a single maskable interrupt. It also holds sticky records of transmit underrun and receive overrun.

Configuration arrives over a small write-only register port with four selectable words: control, DMA levels, interrupt enables and a write-one-to-clear interrupt status. A FIFO flush requested through the control word is not applied at once. It is held until two serial-clock ticks have passed since the last register write, and then it is issued as a one-cycle pulse to the FIFO. A sync flag shows when that two-tick window has closed. The FIFO storage and the serial shifter live outside this block.

Top module: `audio_fifo_ctl`

## Requirements
- R1: With DEPTH the FIFO capacity, tx_empty is high exactly when tx_level is 0, tx_room when tx_level < DEPTH, rx_has when rx_level is nonzero, and rx_full when rx_level equals DEPTH (all combinational).
- R2: rx_need follows the RX code held in control bits [4:3]: code 0 means rx_level >= 1, code 1 means >= DEPTH/2, code 2 means >= 3*DEPTH/4, and code 3 means rx_level == DEPTH.
- R3: tx_need follows the TX code held in control bits [2:1]: code 0 means tx_level == 0, code 1 means <= DEPTH/4, code 2 means <= DEPTH/2, and code 3 means tx_level < DEPTH.
- R4: The DMA word (reg_sel 1) holds the TX request level in bits [6:0] and the RX request level in bits [14:8]. When DMA is on, tx_dreq is high when tx_room is high and tx_level <= the TX request level, and rx_dreq is high when rx_has is high and rx_level >= the RX request level.
- R5: The DMA word holds the TX panic level in bits [22:16] and the RX panic level in bits [30:24]. When DMA is on, tx_panic is high when tx_room is high and tx_level <= the TX panic level, and rx_panic is high when rx_has is high and rx_level >= the RX panic level.
- R6: Control bit 0 turns DMA on. While it is 0, tx_dreq, rx_dreq, tx_panic and rx_panic stay low whatever the levels.
- R7: A tx_underrun pulse sets int_stat[2] and an rx_overrun pulse sets int_stat[3]. Each bit stays set until it is cleared by writing a one.
- R8: int_stat[0] is set on every cycle in which tx_need is high, and int_stat[1] on every cycle in which rx_need is high. A write to reg_sel 3 clears each int_stat bit whose data bit is 1, so 0xF clears all four. A set condition in the same cycle overrides the clear.
- R9: irq is the OR over k of int_stat[k] AND enable[k], where the enables are bits [3:0] of the reg_sel 2 word, in the same bit order as int_stat.
- R10: Writing control (reg_sel 0) with bit 5 (TX) or bit 6 (RX) set schedules a flush. The matching tx_flush or rx_flush pulses high for exactly one cycle, on the cycle after the second ser_tick that follows the last register write.
- R11: Any register write drops sync on the next cycle. sync rises together with the flush timing of R10, once two ser_tick cycles have been seen with no write in between, and then holds.
- R12: After reset all registers are zero, int_stat, irq, sync and both flush outputs are low, and the DMA outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Word select: 0 control, 1 DMA levels, 2 interrupt enables, 3 status clear |
| reg_wdata | input | REG_W | Write data |
| ser_tick | input | 1 | One-cycle pulse per serial clock period |
| tx_level | input | LW | Transmit FIFO fill level |
| rx_level | input | LW | Receive FIFO fill level |
| tx_underrun | input | 1 | Transmit FIFO read while empty |
| rx_overrun | input | 1 | Receive FIFO written while full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_room | output | 1 | Transmit FIFO can take a sample |
| rx_has | output | 1 | Receive FIFO holds data |
| rx_full | output | 1 | Receive FIFO full |
| tx_need | output | 1 | Transmit FIFO needs writing |
| rx_need | output | 1 | Receive FIFO needs reading |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_panic | output | 1 | Transmit panic |
| rx_panic | output | 1 | Receive panic |
| int_stat | output | 4 | Interrupt status: 0 TX write, 1 RX read, 2 TX error, 3 RX error |
| irq | output | 1 | Interrupt line |
| sync | output | 1 | Two serial ticks seen since the last write |
| tx_flush | output | 1 | Flush pulse to the transmit FIFO |
| rx_flush | output | 1 | Flush pulse to the receive FIFO |

## Verification
Several properties are checked on every cycle. Status bits stay set until they are cleared by a one. A set event always lands in the status. A register write always drops sync, a flush pulse lasts a single cycle and only appears while sync is high, and with DMA off no request or panic line rises. Other behaviour needs the bench's scenarios. These are the exact threshold boundaries of every code, the comparison of fill levels against the programmed request and panic levels, the two-tick delay of a flush counted from the last write, and the masking of the interrupt by each enable bit.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int LVL_W = 7;
    localparam int NIRQ  = 4;

    typedef enum logic [1:0] {
        SEL_CTL = 2'd0,
        SEL_DMA = 2'd1,
        SEL_IEN = 2'd2,
        SEL_IST = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] rx_code;
        logic [1:0] tx_code;
        logic       dma_on;
    } ctl_t;

    typedef struct packed {
        logic [LVL_W-1:0] rx_pan;
        logic [LVL_W-1:0] tx_pan;
        logic [LVL_W-1:0] rx_req;
        logic [LVL_W-1:0] tx_req;
    } dma_t;

    // receive service threshold per 2-bit code
    function automatic logic rx_hit(logic [1:0] code, int unsigned lvl, int unsigned dep);
        case (code)
            2'd0:    return lvl >= 1;
            2'd1:    return lvl >= dep / 2;
            2'd2:    return lvl >= (3 * dep) / 4;
            default: return lvl == dep;
        endcase
    endfunction

    // transmit service threshold per 2-bit code
    function automatic logic tx_hit(logic [1:0] code, int unsigned lvl, int unsigned dep);
        case (code)
            2'd0:    return lvl == 0;
            2'd1:    return lvl <= dep / 4;
            2'd2:    return lvl <= dep / 2;
            default: return lvl < dep;
        endcase
    endfunction

endpackage

// File: rtl/afc_regs.sv
module afc_regs
    import afc_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             ser_tick,
    output ctl_t             ctl_q,
    output dma_t             dma_q,
    output logic [NIRQ-1:0]  ien_q,
    output logic             w1c_stb,
    output logic [NIRQ-1:0]  w1c_mask,
    output logic             sync,
    output logic [1:0]       flush_q
);

    localparam int CLR_BIT = 5;

    logic [1:0] tcnt;
    logic       unused_bits;
    logic       ctl_wr;
    logic       tick_done;

    assign unused_bits = ^{reg_wdata[REG_W-1:31], reg_wdata[23], reg_wdata[15], reg_wdata[7]};
    assign ctl_wr      = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTL);
    assign w1c_stb     = reg_wr && (reg_sel_e'(reg_sel) == SEL_IST);
    assign w1c_mask    = reg_wdata[NIRQ-1:0];
    assign sync        = (tcnt == 2'd2);
    assign tick_done   = !reg_wr && ser_tick && (tcnt == 2'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            dma_q <= '0;
            ien_q <= '0;
        end else if (reg_wr) begin
            case (reg_sel_e'(reg_sel))
                SEL_CTL: begin
                    ctl_q.dma_on  <= reg_wdata[0];
                    ctl_q.tx_code <= reg_wdata[2:1];
                    ctl_q.rx_code <= reg_wdata[4:3];
                end
                SEL_DMA: begin
                    dma_q.tx_req <= reg_wdata[6:0];
                    dma_q.rx_req <= reg_wdata[14:8];
                    dma_q.tx_pan <= reg_wdata[22:16];
                    dma_q.rx_pan <= reg_wdata[30:24];
                end
                SEL_IEN: ien_q <= reg_wdata[NIRQ-1:0];
                default: ;
            endcase
        end
    end

    // serial tick counter, restarted by every write, saturates at two
    always_ff @(posedge clk) begin
        if (rst || reg_wr) tcnt <= 2'd0;
        else if (ser_tick && tcnt != 2'd2) tcnt <= tcnt + 2'd1;
    end

    AST_SYNC_DROP: assert property (@(posedge clk) disable iff (rst) reg_wr |=> !sync) else $error("sync held after write"); // R11

    for (genvar k = 0; k < 2; k++) begin : g_clr
        logic pend;
        always_ff @(posedge clk) begin
            if (rst) begin
                pend       <= 1'b0;
                flush_q[k] <= 1'b0;
            end else begin
                flush_q[k] <= pend && tick_done;
                if (ctl_wr && reg_wdata[CLR_BIT+k]) pend <= 1'b1;
                else if (tick_done)                 pend <= 1'b0;
            end
        end

        AST_FLUSH_SYNCED: assert property (@(posedge clk) disable iff (rst) flush_q[k] |-> sync) else $error("flush without sync"); // R10
        AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst) flush_q[k] |=> !flush_q[k]) else $error("flush longer than one cycle"); // R10
    end

endmodule

// File: rtl/afc_flags.sv
module afc_flags
    import afc_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  ctl_t          ctl_q,
    input  dma_t          dma_q,
    output logic          tx_empty,
    output logic          tx_room,
    output logic          rx_has,
    output logic          rx_full,
    output logic          tx_need,
    output logic          rx_need,
    output logic          tx_dreq,
    output logic          rx_dreq,
    output logic          tx_panic,
    output logic          rx_panic
);

    localparam int unsigned DEP = DEPTH;

    int unsigned txl;
    int unsigned rxl;

    always_comb begin
        txl      = 32'(tx_level);
        rxl      = 32'(rx_level);
        tx_empty = (txl == 0);
        tx_room  = (txl < DEP);
        rx_has   = (rxl != 0);
        rx_full  = (rxl == DEP);
        tx_need  = tx_hit(ctl_q.tx_code, txl, DEP);
        rx_need  = rx_hit(ctl_q.rx_code, rxl, DEP);
        tx_dreq  = ctl_q.dma_on && tx_room && (txl <= 32'(dma_q.tx_req));
        rx_dreq  = ctl_q.dma_on && rx_has  && (rxl >= 32'(dma_q.rx_req));
        tx_panic = ctl_q.dma_on && tx_room && (txl <= 32'(dma_q.tx_pan));
        rx_panic = ctl_q.dma_on && rx_has  && (rxl >= 32'(dma_q.rx_pan));
    end

endmodule

// File: rtl/afc_irq.sv
module afc_irq
    import afc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] set_vec,
    input  logic            w1c_stb,
    input  logic [NIRQ-1:0] w1c_mask,
    input  logic [NIRQ-1:0] ien_q,
    output logic [NIRQ-1:0] int_stat,
    output logic            irq
);

    for (genvar k = 0; k < NIRQ; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                          int_stat[k] <= 1'b0;
            else if (set_vec[k])              int_stat[k] <= 1'b1;
            else if (w1c_stb && w1c_mask[k])  int_stat[k] <= 1'b0;
        end

        AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
            (int_stat[k] && !(w1c_stb && w1c_mask[k])) |=> int_stat[k]) else $error("status bit lost"); // R7
        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_vec[k] |=> int_stat[k]) else $error("set event dropped"); // R8
    end

    assign irq = |(int_stat & ien_q);

endmodule

// File: rtl/audio_fifo_ctl.sv
module audio_fifo_ctl
    import afc_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int REG_W = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             ser_tick,
    input  logic [LW-1:0]    tx_level,
    input  logic [LW-1:0]    rx_level,
    input  logic             tx_underrun,
    input  logic             rx_overrun,
    output logic             tx_empty,
    output logic             tx_room,
    output logic             rx_has,
    output logic             rx_full,
    output logic             tx_need,
    output logic             rx_need,
    output logic             tx_dreq,
    output logic             rx_dreq,
    output logic             tx_panic,
    output logic             rx_panic,
    output logic [3:0]       int_stat,
    output logic             irq,
    output logic             sync,
    output logic             tx_flush,
    output logic             rx_flush
);

    ctl_t            ctl_q;
    dma_t            dma_q;
    logic [NIRQ-1:0] ien_q;
    logic            w1c_stb;
    logic [NIRQ-1:0] w1c_mask;
    logic [1:0]      flush_q;
    logic [NIRQ-1:0] set_vec;

    afc_regs #(.REG_W(REG_W)) regs_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ser_tick(ser_tick), .ctl_q(ctl_q),
        .dma_q(dma_q), .ien_q(ien_q), .w1c_stb(w1c_stb),
        .w1c_mask(w1c_mask), .sync(sync), .flush_q(flush_q)
    );

    afc_flags #(.DEPTH(DEPTH)) flags_i (
        .tx_level(tx_level), .rx_level(rx_level), .ctl_q(ctl_q), .dma_q(dma_q),
        .tx_empty(tx_empty), .tx_room(tx_room), .rx_has(rx_has), .rx_full(rx_full),
        .tx_need(tx_need), .rx_need(rx_need), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
        .tx_panic(tx_panic), .rx_panic(rx_panic)
    );

    assign set_vec = {rx_overrun, tx_underrun, rx_need, tx_need};

    afc_irq irq_i (
        .clk(clk), .rst(rst), .set_vec(set_vec), .w1c_stb(w1c_stb),
        .w1c_mask(w1c_mask), .ien_q(ien_q), .int_stat(int_stat), .irq(irq)
    );

    assign tx_flush = flush_q[0];
    assign rx_flush = flush_q[1];

    AST_DMA_GATED: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.dma_on |-> !(tx_dreq || rx_dreq || tx_panic || rx_panic)) else $error("DMA line while off"); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq) else $error("irq with all enables off"); // R9

endmodule

// File: tb/audio_fifo_ctl_tb_top.sv
`timescale 1ns/1ps
module audio_fifo_ctl_tb_top;

    localparam int D  = 64;
    localparam int LW = $clog2(D + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic ser_tick = 1'b0;
    logic [LW-1:0] tx_level = '0;
    logic [LW-1:0] rx_level = '0;
    logic tx_underrun = 1'b0;
    logic rx_overrun = 1'b0;
    logic tx_empty, tx_room, rx_has, rx_full, tx_need, rx_need;
    logic tx_dreq, rx_dreq, tx_panic, rx_panic, irq, sync, tx_flush, rx_flush;
    logic [3:0] int_stat;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    audio_fifo_ctl #(.DEPTH(D), .REG_W(32)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ser_tick(ser_tick), .tx_level(tx_level), .rx_level(rx_level),
        .tx_underrun(tx_underrun), .rx_overrun(rx_overrun),
        .tx_empty(tx_empty), .tx_room(tx_room), .rx_has(rx_has), .rx_full(rx_full),
        .tx_need(tx_need), .rx_need(rx_need), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
        .tx_panic(tx_panic), .rx_panic(rx_panic), .int_stat(int_stat), .irq(irq),
        .sync(sync), .tx_flush(tx_flush), .rx_flush(rx_flush)
    );

    function automatic bit m_rx(int code, int l);
        case (code)
            0: return l >= 1;
            1: return l >= D / 2;
            2: return l >= (3 * D) / 4;
            default: return l == D;
        endcase
    endfunction

    function automatic bit m_tx(int code, int l);
        case (code)
            0: return l == 0;
            1: return l <= D / 4;
            2: return l <= D / 2;
            default: return l < D;
        endcase
    endfunction

    task automatic check(string req, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic wr(int sel, logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel[1:0]; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk);
        ser_tick = 1'b1;
        @(negedge clk);
        ser_tick = 1'b0;
    endtask

    // model of every combinational output
    task automatic check_comb(int txc, int rxc, bit dma, int treq, int rreq, int tpan, int rpan);
        int tl = int'(tx_level);
        int rl = int'(rx_level);
        bit troom = tl < D;
        bit rhas = rl != 0;
        #1;
        check("R1", "tx_empty", tx_empty, tl == 0);
        check("R1", "tx_room", tx_room, troom);
        check("R1", "rx_has", rx_has, rhas);
        check("R1", "rx_full", rx_full, rl == D);
        check("R3", "tx_need", tx_need, m_tx(txc, tl));
        check("R2", "rx_need", rx_need, m_rx(rxc, rl));
        check("R4", "tx_dreq", tx_dreq, dma && troom && tl <= treq);
        check("R4", "rx_dreq", rx_dreq, dma && rhas && rl >= rreq);
        check("R5", "tx_panic", tx_panic, dma && troom && tl <= tpan);
        check("R5", "rx_panic", rx_panic, dma && rhas && rl >= rpan);
    endtask

    function automatic int pick_level();
        int r = int'($urandom_range(0, 9));
        if (r == 0) return 0;
        if (r == 1) return D;
        if (r == 2) return D - 1;
        return int'($urandom_range(0, D));
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R12: state straight after reset
        check("R12", "int_stat", int_stat, 0);
        check("R12", "irq", irq, 0);
        check("R12", "sync", sync, 0);
        check("R12", "tx_flush", tx_flush, 0);
        check("R12", "rx_flush", rx_flush, 0);
        check("R12", "tx_dreq", tx_dreq, 0);
        check("R12", "tx_need", tx_need, 1);

        // directed threshold boundaries, R2 and R3
        for (int code = 0; code < 4; code++) begin
            int pts[10] = '{0, 1, D/4, D/4+1, D/2-1, D/2, (3*D)/4-1, (3*D)/4, D-1, D};
            wr(0, 32'((code << 3) | (code << 1)));
            foreach (pts[i]) begin
                tx_level = LW'(pts[i]);
                rx_level = LW'(pts[i]);
                check_comb(code, code, 1'b0, 0, 0, 0, 0);
            end
        end

        // R6: DMA off ignores levels, then on
        wr(1, {1'b0, 7'd127, 1'b0, 7'd127, 1'b0, 7'd1, 1'b0, 7'd127});
        wr(0, 32'd0);
        tx_level = LW'(D/2); rx_level = LW'(D/2);
        #1;
        check("R6", "tx_dreq off", tx_dreq, 0);
        check("R6", "rx_dreq off", rx_dreq, 0);
        check("R6", "tx_panic off", tx_panic, 0);
        check("R6", "rx_panic off", rx_panic, 0);
        wr(0, 32'd1);
        check_comb(0, 0, 1'b1, 127, 1, 127, 127);

        // random configuration and levels
        for (int it = 0; it < 300; it++) begin
            int txc = int'($urandom_range(0, 3));
            int rxc = int'($urandom_range(0, 3));
            bit dma = 1'($urandom_range(0, 1));
            int treq = int'($urandom_range(0, 127));
            int rreq = int'($urandom_range(0, 127));
            int tpan = int'($urandom_range(0, 127));
            int rpan = int'($urandom_range(0, 127));
            if (it % 3 == 0) begin treq = int'($urandom_range(0, D)); rreq = int'($urandom_range(0, D)); end
            wr(0, 32'((rxc << 3) | (txc << 1) | int'(dma)));
            wr(1, 32'((rpan << 24) | (tpan << 16) | (rreq << 8) | treq));
            tx_level = LW'(pick_level());
            rx_level = LW'(pick_level());
            check_comb(txc, rxc, dma, treq, rreq, tpan, rpan);
        end

        // R10 / R11: flush after two ticks from last write
        wr(0, 32'h60);
        check("R11", "sync after write", sync, 0);
        tick_once();
        check("R10", "tx_flush early", tx_flush, 0);
        check("R11", "sync after one tick", sync, 0);
        tick_once();
        check("R10", "tx_flush", tx_flush, 1);
        check("R10", "rx_flush", rx_flush, 1);
        check("R11", "sync", sync, 1);
        @(negedge clk);
        check("R10", "tx_flush width", tx_flush, 0);
        check("R11", "sync holds", sync, 1);
        // second write restarts the count
        wr(0, 32'h20);
        tick_once();
        wr(2, 32'h0);
        tick_once();
        check("R10", "tx_flush after restart", tx_flush, 0);
        tick_once();
        check("R10", "tx_flush delayed", tx_flush, 1);
        check("R10", "rx_flush not requested", rx_flush, 0);

        // R7 / R8 / R9: interrupt status
        wr(0, 32'd0);
        tx_level = LW'(D); rx_level = '0;
        wr(2, 32'h0);
        wr(3, 32'hF);
        check("R8", "all cleared", int_stat, 0);
        @(negedge clk); tx_underrun = 1'b1;
        @(negedge clk); tx_underrun = 1'b0;
        check("R7", "underrun bit", int_stat, 4'b0100);
        check("R9", "irq masked", irq, 0);
        repeat (3) @(negedge clk);
        check("R7", "underrun sticky", int_stat, 4'b0100);
        wr(2, 32'h4);
        check("R9", "irq enabled", irq, 1);
        wr(3, 32'h4);
        check("R7", "w1c underrun", int_stat, 0);
        check("R9", "irq gone", irq, 0);
        @(negedge clk); rx_overrun = 1'b1;
        @(negedge clk); rx_overrun = 1'b0;
        check("R7", "overrun bit", int_stat, 4'b1000);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 32'h8; rx_overrun = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; rx_overrun = 1'b0;
        check("R8", "set beats clear", int_stat, 4'b1000);
        wr(3, 32'h8);
        check("R8", "w1c overrun", int_stat, 0);
        tx_level = '0;
        @(negedge clk);
        check("R8", "tx service set", int_stat, 4'b0001);
        wr(2, 32'h1);
        check("R9", "irq tx service", irq, 1);
        wr(3, 32'h1);
        check("R8", "service re-set while needed", int_stat, 4'b0001);
        tx_level = LW'(D);
        wr(3, 32'h1);
        check("R8", "service cleared", int_stat, 0);
        check("R9", "irq low", irq, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule